// File: doc/BRIEF.md
# Line-Cycle Energy Accumulation Controller

This block publishes per-phase active energy only at boundaries aligned to the mains waveform. While the mode is on, per-sample energy increments for three phases are summed into private accumulators. A chosen subset of the three phase zero-crossing pulses is counted. When the number of counted half line cycles reaches a programmed value, the private totals are copied into the three visible watt-hour registers, and a sticky completion flag is raised. Because each period covers a whole number of half cycles, the ripple that sinusoidal power puts on the energy cancels. This makes short calibration runs practical.

While the mode is off, the visible registers sum the increments directly, and a read strobe can clear the register it addresses. While the mode is on, that read-with-reset is suppressed so that the published totals are never disturbed.

Top module: `line_cycle_energy`

## Requirements
- R1: While `lc_en` is low, the half-cycle counter and private accumulators are held at zero, and each visible register adds its phase's sign-extended increment every cycle, wrapping in two's complement.
- R2: While `lc_en` is low, a cycle with `rd_stb` and `rd_clr_en` both high sets the register chosen by `rd_sel` to zero instead of adding to it. The encoding is 0 = A, 1 = B, 2 = C; 3 selects none.
- R3: While `lc_en` is high, read strobes never change a visible register, whatever `rd_clr_en` is.
- R4: `zx_sel` bit 0 admits phase A pulses, bit 1 admits phase B and bit 2 admits phase C. Any combination is allowed, and pulses from unselected phases have no effect.
- R5: After `lc_en` rises, nothing is accumulated until the first cycle that carries a selected pulse. That cycle opens the period with the count at zero and the accumulators loaded with that cycle's increments. Further pulses in that cycle are not counted.
- R6: In every later cycle the counter advances by the number of selected pulses present in that cycle (0 to 3).
- R7: When the advanced count reaches or passes a nonzero `half_cycles`, each visible register takes its private accumulator value, which excludes that cycle's increment. The accumulators restart from that cycle's increment, the counter returns to zero and any excess count is dropped.
- R8: While `lc_en` is high, the visible registers change only at a transfer.
- R9: A `half_cycles` value of 0 disables transfers. The counter then stays at zero, and the accumulators keep summing.
- R10: `done` is set by each transfer and stays set until a cycle with `done_clr` high. A transfer in that same cycle keeps it set.
- R11: After reset, all visible registers read zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lc_en | input | 1 | Line-cycle mode enable |
| zx_sel | input | 3 | Phase C/B/A zero-crossing admit mask |
| half_cycles | input | CNT_W | Half line cycles per period (0 disables transfers) |
| zx_pulse | input | 3 | One-cycle zero-crossing pulses, phases C/B/A |
| inc_a | input | INC_W | Signed energy increment, phase A |
| inc_b | input | INC_W | Signed energy increment, phase B |
| inc_c | input | INC_W | Signed energy increment, phase C |
| rd_clr_en | input | 1 | Read-with-reset control |
| rd_stb | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register addressed by the read |
| done_clr | input | 1 | Write-one-to-clear of the completion flag |
| wh_a | output | ACC_W | Visible watt-hour register, phase A |
| wh_b | output | ACC_W | Visible watt-hour register, phase B |
| wh_c | output | ACC_W | Visible watt-hour register, phase C |
| done | output | 1 | Sticky transfer-complete flag |

## Verification
The bench sweeps every nonzero select mask against several period lengths, using pulse patterns that include two or three phases in the same cycle. This exposes a counter that adds one per cycle instead of one per pulse, or that lets an unselected phase through. It checks the increment that lands in the opening cycle and in the transfer cycle. A design that misplaces either of them publishes totals off by one sample, or loses energy across a boundary. It also covers a zero period, which an unguarded compare would treat as an immediate transfer. It covers read-with-reset issued while the mode is on, which a missing guard would turn into a zeroed register. Finally, it covers a flag clear that coincides with a transfer, where giving the clear priority would lose the completion flag.

// File: rtl/line_cycle_energy.sv
module line_cycle_energy #(
  parameter int ACC_W = 32,
  parameter int INC_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lc_en,
  input  logic [2:0]              zx_sel,
  input  logic [CNT_W-1:0]        half_cycles,
  input  logic [2:0]              zx_pulse,
  input  logic signed [INC_W-1:0] inc_a,
  input  logic signed [INC_W-1:0] inc_b,
  input  logic signed [INC_W-1:0] inc_c,
  input  logic                    rd_clr_en,
  input  logic                    rd_stb,
  input  logic [1:0]              rd_sel,
  input  logic                    done_clr,
  output logic [ACC_W-1:0]        wh_a,
  output logic [ACC_W-1:0]        wh_b,
  output logic [ACC_W-1:0]        wh_c,
  output logic                    done
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic             started;
  logic [ACC_W-1:0] acc [3];
  logic [ACC_W-1:0] wh  [3];
  logic [ACC_W-1:0] ext [3];

  wire [2:0]       hits    = zx_pulse & zx_sel;
  wire [SUM_W-1:0] nhit    = SUM_W'(hits[0]) + SUM_W'(hits[1]) + SUM_W'(hits[2]);
  wire [SUM_W-1:0] cnt_sum = {1'b0, cnt} + nhit;
  wire             no_per  = (half_cycles == '0);
  wire             run     = lc_en && started;
  wire             opening = lc_en && !started && (|hits);
  wire             xfer    = run && !no_per && (cnt_sum >= {1'b0, half_cycles});

  assign ext[0] = {{(ACC_W-INC_W){inc_a[INC_W-1]}}, inc_a};
  assign ext[1] = {{(ACC_W-INC_W){inc_b[INC_W-1]}}, inc_b};
  assign ext[2] = {{(ACC_W-INC_W){inc_c[INC_W-1]}}, inc_c};
  assign wh_a = wh[0];
  assign wh_b = wh[1];
  assign wh_c = wh[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      started <= 1'b0;
      done    <= 1'b0;
    end else begin
      started <= lc_en && (started || (|hits));
      if (!lc_en || xfer || opening || no_per) cnt <= '0;
      else if (run)                             cnt <= cnt_sum[CNT_W-1:0];
      if (xfer)          done <= 1'b1;
      else if (done_clr) done <= 1'b0;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_phase
    wire rd_clr = rd_stb && rd_clr_en && (rd_sel == 2'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc[i] <= '0;
        wh[i]  <= '0;
      end else if (!lc_en) begin
        acc[i] <= '0;
        wh[i]  <= rd_clr ? '0 : wh[i] + ext[i];
      end else begin
        if (xfer || opening) acc[i] <= ext[i];
        else if (run)        acc[i] <= acc[i] + ext[i];
        if (xfer) wh[i] <= acc[i];
      end
    end

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (lc_en && !xfer) |=> $stable(wh[i]));
    a_r7_publish: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (wh[i] == $past(acc[i])));
  end

  a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lc_en |=> (cnt == '0 && !started && acc[0] == '0));
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (cnt == '0 && done));
  a_r9_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_en && no_per && done_clr) |=> !done);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);
endmodule

// File: tb/tb_line_cycle_energy.sv
module tb_line_cycle_energy;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lc_en = 1'b0;
  logic [2:0] zx_sel = 3'b001;
  logic [15:0] half_cycles = 16'd1;
  logic [2:0] zx_pulse = 3'b000;
  logic signed [15:0] inc_a = '0, inc_b = '0, inc_c = '0;
  logic rd_clr_en = 1'b0, rd_stb = 1'b0, done_clr = 1'b0;
  logic [1:0] rd_sel = 2'd0;
  logic [31:0] wh_a, wh_b, wh_c;
  logic done;

  int checks = 0, failures = 0;
  logic [31:0] m_wh [3];
  logic [31:0] m_acc [3];
  int m_cnt;
  bit m_started, m_done;

  always #4 clk = ~clk;

  line_cycle_energy dut (
    .clk(clk), .rst_n(rst_n), .lc_en(lc_en), .zx_sel(zx_sel),
    .half_cycles(half_cycles), .zx_pulse(zx_pulse),
    .inc_a(inc_a), .inc_b(inc_b), .inc_c(inc_c),
    .rd_clr_en(rd_clr_en), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .done_clr(done_clr), .wh_a(wh_a), .wh_b(wh_b), .wh_c(wh_c), .done(done));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(wh_a, m_wh[0], {tag, " wh_a"});
    chk(wh_b, m_wh[1], {tag, " wh_b"});
    chk(wh_c, m_wh[2], {tag, " wh_c"});
    chk(32'(done), 32'(m_done), {tag, " done"});
  endtask

  task automatic model_edge();
    logic [31:0] e [3];
    int p, s;
    bit xf;
    e[0] = 32'(inc_a); e[1] = 32'(inc_b); e[2] = 32'(inc_c);
    xf = 0;
    if (!lc_en) begin
      m_cnt = 0; m_started = 0;
      for (int i = 0; i < 3; i++) begin
        m_acc[i] = 0;
        if (rd_stb && rd_clr_en && rd_sel == 2'(i)) m_wh[i] = 0;
        else m_wh[i] = m_wh[i] + e[i];
      end
    end else begin
      p = $countones(zx_pulse & zx_sel);
      if (!m_started) begin
        if (p > 0) begin
          m_started = 1; m_cnt = 0;
          for (int i = 0; i < 3; i++) m_acc[i] = e[i];
        end
      end else begin
        s = m_cnt + p;
        if (half_cycles != 0 && s >= int'(half_cycles)) begin
          xf = 1; m_cnt = 0;
          for (int i = 0; i < 3; i++) begin m_wh[i] = m_acc[i]; m_acc[i] = e[i]; end
        end else begin
          m_cnt = (half_cycles == 0) ? 0 : s;
          for (int i = 0; i < 3; i++) m_acc[i] = m_acc[i] + e[i];
        end
      end
    end
    if (xf) m_done = 1;
    else if (done_clr) m_done = 0;
  endtask

  task automatic step(input logic [2:0] z, input int ia, input int ib, input int ic, input string tag);
    zx_pulse = z; inc_a = 16'(ia); inc_b = 16'(ib); inc_c = 16'(ic);
    @(posedge clk);
    model_edge();
    #2;
    chk_all(tag);
    zx_pulse = '0; rd_stb = 0; done_clr = 0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    for (int i = 0; i < 3; i++) begin m_wh[i] = 0; m_acc[i] = 0; end
    m_cnt = 0; m_started = 0; m_done = 0;
    #20;
    chk_all("R11 in reset");
    @(negedge clk); rst_n = 1;
    #1; chk_all("R11 after reset");

    // R1: direct accumulation with wrap
    step(3'b111, 100, -5, 32767, "R1");
    step(3'b000, 7, -5, 32767, "R1");
    chk(wh_b, 32'hFFFF_FFF6, "R1 negative sum");
    // R2: read-with-reset when off
    rd_clr_en = 1; rd_stb = 1; rd_sel = 2'd1;
    step(3'b000, 1, 50, 1, "R2");
    chk(wh_b, 32'd0, "R2 cleared B");
    rd_stb = 1; rd_sel = 2'd3;
    step(3'b000, 1, 1, 1, "R2 sel none");
    rd_stb = 1; rd_sel = 2'd0; rd_clr_en = 0;
    step(3'b000, 2, 2, 2, "R2 no clr_en");

    // R5 + R3: enable, pre-start increments ignored, read-with-reset suppressed
    lc_en = 1; zx_sel = 3'b001; half_cycles = 16'd1; rd_clr_en = 1;
    snap = wh_a;
    step(3'b000, 9, 9, 9, "R5 pre-start");
    rd_stb = 1; rd_sel = 2'd0;
    step(3'b110, 9, 9, 9, "R3 read on");
    chk(wh_a, snap, "R3 wh_a kept");
    step(3'b001, 10, 20, 30, "R5 opening");
    step(3'b000, 1, 2, 3, "R8 hold");
    step(3'b001, 500, 500, 500, "R7 transfer");
    chk(wh_a, 32'd11, "R7 wh_a value");
    chk(wh_c, 32'd33, "R7 wh_c value");
    // R10: clear coinciding with transfer keeps flag
    done_clr = 1;
    step(3'b001, 4, 4, 4, "R10 set wins");
    chk(32'(done), 32'd1, "R10 still set");
    chk(wh_a, 32'd500, "R7 restart from boundary increment");
    done_clr = 1;
    step(3'b000, 0, 0, 0, "R10 clear");
    chk(32'(done), 32'd0, "R10 cleared");

    // R6: three pulses in one cycle with period 3
    lc_en = 0; step(3'b000, 0, 0, 0, "R1 off");
    lc_en = 1; zx_sel = 3'b111; half_cycles = 16'd3;
    step(3'b010, 5, 5, 5, "R6 open");
    step(3'b111, 6, 6, 6, "R6 triple");
    chk(wh_a, 32'd5, "R6 triple transfers");

    // R9: zero period
    done_clr = 1; half_cycles = 16'd0;
    step(3'b111, 1, 1, 1, "R9");
    for (int k = 0; k < 10; k++) step(3'b111, k, -k, 3, "R9 no transfer");
    chk(32'(done), 32'd0, "R9 done stays low");
    half_cycles = 16'd2;
    step(3'b000, 1, 1, 1, "R9 resume");
    step(3'b011, 1, 1, 1, "R9 resumed transfer");

    // R4 R6 R7 R8 R3 sweep: every mask, several periods
    for (int s = 1; s < 8; s++) begin
      for (int n = 1; n <= 4; n++) begin
        lc_en = 0; rd_clr_en = 0;
        step(3'b000, s, n, -s, "R1 sweep off");
        lc_en = 1; zx_sel = 3'(s); half_cycles = 16'(n);
        for (int k = 0; k < 40; k++) begin
          if (k % 7 == 3) begin rd_stb = 1; rd_clr_en = 1; rd_sel = 2'(k % 3); end
          if (k % 11 == 5) done_clr = 1;
          step(((k % 3) == 0) ? 3'((k * 5 + n) & 7) : 3'b000,
               k * 3 + s - 20, 100 * n - k, -(k + 1), "R4 R6 R7 R8 sweep");
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule